// File: doc/BRIEF.md
# SPI Flash Status and Write-Enable Controller

This block is the command-side control of a serial flash slave. It watches a mode-0 serial port made of a serial clock, an active-low select and a data input. The port is oversampled in the fabric clock domain. The block collects the first byte of each frame as an opcode and the next three bytes as an address. It owns two 8-bit status registers. These hold a busy flag, a write-permission latch, a quad-enable bit, a suspend flag and freely writable configuration bits. Two opcodes return either register on the data output.

Commands that change the memory or the status bits take effect only at the moment select goes high. They take effect only if the frame had exactly the length the command needs. They are refused unless the write-permission latch was set beforehand. An accepted program, erase or status write raises busy and pulses a start strobe to the array side, with the opcode and the address. The array side answers with a one-cycle done pulse. That pulse ends busy and drops the latch. A suspend opcode can pause a running erase or program. A resume opcode restarts it. Both are gated on the busy and suspend bits. While the block is suspended, status writes and every erase opcode are refused.

Top module: `spi_status_ctrl`

## Requirements
- R1: Opcode 06h in a frame of exactly 8 bits sets the write-permission latch (status-1 bit 1). Opcode 04h in a frame of exactly 8 bits clears it. Either opcode in a frame of any other length changes nothing.
- R2: After opcode 05h, data output carries status register 1, and after opcode 35h it carries status register 2. Bits go out MSB first and change on each falling serial-clock edge, starting at the fall that follows the 8th rising edge. The byte repeats for as long as select stays low.
- R3: After reset, both status registers read 00h, so quad-enable (status-2 bit 1) is 0, and no strobe is pulsed.
- R4: Program (02h, 32h, 42h), erase (20h, 52h, D8h, C7h, 60h, 44h) and status write (01h) are ignored when the write-permission latch is 0.
- R5: Status write 01h is accepted only in a frame of 16 or 24 bits. With 16 bits, the data byte sets status-1 bits 7:2. With 24 bits, the second byte also sets status-2 bits 6:0. Status-1 bits 1:0 and status-2 bit 7 are never written. Any other frame length discards the write.
- R6: An accepted program, erase or status write pulses op_start for one cycle, with op_code and op_addr, and sets busy (status-1 bit 0). Address erases need exactly 32 bits. Chip erases need exactly 8 bits. Programs need 40 to 32+8*PAGE_BYTES bits, in whole bytes. Status write and chip erase report address 0. At most one of op_start, sus_req and res_req is high in any cycle.
- R7: op_done while busy clears busy and the write-permission latch.
- R8: While busy, every opcode except 05h, 35h and a valid 75h is ignored.
- R9: Opcode 75h, 8 bits, while busy with an erase or program and not already suspended, sets the suspend flag (status-2 bit 7), clears busy and pulses sus_req. During a status write it is ignored.
- R10: Opcode 7Ah, 8 bits, is accepted only when the suspend flag is 1 and busy is 0. It then clears the suspend flag, sets busy and pulses res_req.
- R11: While the suspend flag is 1, status write and all erase opcodes are refused. Program and latch commands are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low frame select |
| di | input | 1 | Serial data in, sampled on rising serial-clock edges |
| op_done | input | 1 | One-cycle pulse from the array side when an operation ends |
| do_o | output | 1 | Serial status data out, 0 when not reading |
| op_start | output | 1 | One-cycle pulse starting an array operation |
| op_code | output | 8 | Opcode of the started operation |
| op_addr | output | 24 | Address of the started operation |
| sus_req | output | 1 | One-cycle pulse asking the array side to pause |
| res_req | output | 1 | One-cycle pulse asking the array side to continue |

## Verification
The checker takes three things for granted about the inputs. First, op_done arrives only while busy is set. Second, op_done never lands in the same cycle as a frame end. Third, every serial-clock and select level is held for several fabric cycles, so the synchronisers see each edge once. The stimulus holds each serial-clock phase for eight fabric cycles and changes data a half period ahead of the rising edge. It pulses op_done on a falling fabric edge only after a frame has finished and its effect has been read back.

// File: rtl/spi_st_pkg.sv
package spi_st_pkg;

  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_RD_STAT1  = 8'h05;
  localparam logic [7:0] OP_RD_STAT2  = 8'h35;
  localparam logic [7:0] OP_WR_STAT   = 8'h01;
  localparam logic [7:0] OP_PAUSE     = 8'h75;
  localparam logic [7:0] OP_CONTINUE  = 8'h7A;

  // Writable bits of each status register
  localparam logic [7:0] STAT1_WMASK = 8'hFC;
  localparam logic [7:0] STAT2_WMASK = 8'h7F;

  localparam int B_BUSY  = 0;  // status-1
  localparam int B_LATCH = 1;  // status-1
  localparam int B_QUAD  = 1;  // status-2
  localparam int B_PAUSE = 7;  // status-2

  typedef enum logic [2:0] {
    CK_NONE, CK_LATCH_ON, CK_LATCH_OFF, CK_STWR,
    CK_ER_ADDR, CK_ER_ALL, CK_PROG, CK_PAUSE_RES
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [7:0] op);
    case (op)
      OP_LATCH_ON:                 return CK_LATCH_ON;
      OP_LATCH_OFF:                return CK_LATCH_OFF;
      OP_WR_STAT:                  return CK_STWR;
      8'h20, 8'h52, 8'hD8, 8'h44:  return CK_ER_ADDR;
      8'hC7, 8'h60:                return CK_ER_ALL;
      8'h02, 8'h32, 8'h42:         return CK_PROG;
      OP_PAUSE, OP_CONTINUE:       return CK_PAUSE_RES;
      default:                     return CK_NONE;
    endcase
  endfunction

  function automatic logic is_erase(input logic [7:0] op);
    cmd_kind_e k;
    k = classify(op);
    return (k == CK_ER_ADDR) || (k == CK_ER_ALL);
  endfunction

endpackage

// File: rtl/spi_st_frontend.sv
module spi_st_frontend #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             di,
  output logic             sel,
  output logic             sclk_rise,
  output logic             sclk_fall,
  output logic             frame_end,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opcode,
  output logic [23:0]      addr,
  output logic [15:0]      tail
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]  sclk_p;
  logic [2:0]  cs_p;
  logic [1:0]  di_p;
  logic [22:0] sh;

  assign sel       = ~cs_p[1];
  assign sclk_rise = sclk_p[1] & ~sclk_p[2];
  assign sclk_fall = ~sclk_p[1] & sclk_p[2];
  assign frame_end = cs_p[1] & ~cs_p[2];
  assign tail      = sh[15:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      di_p   <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      cs_p   <= {cs_p[1:0], cs_n};
      di_p   <= {di_p[0], di};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      sh      <= '0;
      opcode  <= '0;
      addr    <= '0;
    end else if (!sel) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      sh <= {sh[21:0], di_p[1]};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(7))  opcode <= {sh[6:0], di_p[1]};
      if (bit_cnt == CNT_W'(31)) addr   <= {sh[22:0], di_p[1]};
    end
  end
endmodule

// File: rtl/spi_st_readout.sv
module spi_st_readout
  import spi_st_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  logic       sclk_fall,
  input  logic       rd_phase,
  input  logic [7:0] opcode,
  input  logic [7:0] stat1,
  input  logic [7:0] stat2,
  output logic       do_o
);
  logic [2:0] idx;
  logic [7:0] cur;
  logic       active;

  always_comb begin
    cur    = (opcode == OP_RD_STAT2) ? stat2 : stat1;
    active = rd_phase && ((opcode == OP_RD_STAT1) || (opcode == OP_RD_STAT2));
  end

  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      idx  <= '0;
      do_o <= 1'b0;
    end else if (sclk_fall && active) begin
      do_o <= cur[3'd7 - idx];
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/spi_st_core.sv
module spi_st_core
  import spi_st_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PAGE_BYTES = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_end,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic [7:0]       opcode,
  input  logic [23:0]      addr,
  input  logic [15:0]      tail,
  input  logic             op_done,
  output logic [7:0]       stat1,
  output logic [7:0]       stat2,
  output logic             op_start,
  output logic [7:0]       op_code,
  output logic [23:0]      op_addr,
  output logic             sus_req,
  output logic             res_req
);
  localparam int PROG_MAX = 32 + 8 * PAGE_BYTES;

  cmd_kind_e  kind;
  logic       len8, len16, len24, len32, len_prog;
  logic       busy, latch, paused, pe_run;
  logic       acc_on, acc_off, acc_wr, acc_er, acc_pg, acc_sus, acc_res;
  logic [7:0] wr1;

  assign busy   = stat1[B_BUSY];
  assign latch  = stat1[B_LATCH];
  assign paused = stat2[B_PAUSE];

  always_comb begin
    kind     = classify(opcode);
    len8     = bit_cnt == CNT_W'(8);
    len16    = bit_cnt == CNT_W'(16);
    len24    = bit_cnt == CNT_W'(24);
    len32    = bit_cnt == CNT_W'(32);
    len_prog = (bit_cnt >= CNT_W'(40)) && (bit_cnt <= CNT_W'(PROG_MAX))
               && (bit_cnt[2:0] == 3'd0);
    acc_on   = frame_end && kind == CK_LATCH_ON  && len8 && !busy;
    acc_off  = frame_end && kind == CK_LATCH_OFF && len8 && !busy;
    acc_wr   = frame_end && kind == CK_STWR && (len16 || len24)
               && !busy && latch && !paused;
    acc_er   = frame_end && ((kind == CK_ER_ADDR && len32) || (kind == CK_ER_ALL && len8))
               && !busy && latch && !paused;
    acc_pg   = frame_end && kind == CK_PROG && len_prog && !busy && latch;
    acc_sus  = frame_end && opcode == OP_PAUSE && len8 && busy && pe_run && !paused;
    acc_res  = frame_end && opcode == OP_CONTINUE && len8 && !busy && paused;
    wr1      = len24 ? tail[15:8] : tail[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat1    <= '0;
      stat2    <= '0;
      op_start <= 1'b0;
      op_code  <= '0;
      op_addr  <= '0;
      sus_req  <= 1'b0;
      res_req  <= 1'b0;
      pe_run   <= 1'b0;
    end else begin
      op_start <= acc_wr | acc_er | acc_pg;
      sus_req  <= acc_sus;
      res_req  <= acc_res;
      if (acc_on)  stat1[B_LATCH] <= 1'b1;
      if (acc_off) stat1[B_LATCH] <= 1'b0;
      if (acc_wr) begin
        stat1 <= (stat1 & ~STAT1_WMASK) | (wr1 & STAT1_WMASK);
        if (len24) stat2 <= (stat2 & ~STAT2_WMASK) | (tail[7:0] & STAT2_WMASK);
      end
      if (acc_wr || acc_er || acc_pg) begin
        op_code        <= opcode;
        op_addr        <= ((acc_er && len32) || acc_pg) ? addr : 24'h0;
        stat1[B_BUSY]  <= 1'b1;
        pe_run         <= !acc_wr;
      end
      if (acc_sus) begin
        stat1[B_BUSY]  <= 1'b0;
        stat2[B_PAUSE] <= 1'b1;
      end
      if (acc_res) begin
        stat1[B_BUSY]  <= 1'b1;
        stat2[B_PAUSE] <= 1'b0;
        pe_run         <= 1'b1;
      end
      if (op_done && busy) begin
        stat1[B_BUSY]  <= 1'b0;
        stat1[B_LATCH] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int PAGE_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        di,
  input  logic        op_done,
  output logic        do_o,
  output logic        op_start,
  output logic [7:0]  op_code,
  output logic [23:0] op_addr,
  output logic        sus_req,
  output logic        res_req
);
  localparam int CNT_W = $clog2(32 + 8 * PAGE_BYTES + 2);

  logic             sel, sclk_rise, sclk_fall, frame_end, rd_phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       opcode;
  logic [23:0]      addr;
  logic [15:0]      tail;
  logic [7:0]       stat1_w, stat2_w;
  logic             unused_rise;

  assign rd_phase    = sel && (bit_cnt >= CNT_W'(8));
  assign unused_rise = sclk_rise;

  spi_st_frontend #(.CNT_W(CNT_W)) u_front (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .di(di),
    .sel(sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .frame_end(frame_end), .bit_cnt(bit_cnt), .opcode(opcode),
    .addr(addr), .tail(tail)
  );

  spi_st_core #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_core (
    .clk(clk), .rst(rst), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .opcode(opcode), .addr(addr), .tail(tail), .op_done(op_done),
    .stat1(stat1_w), .stat2(stat2_w), .op_start(op_start),
    .op_code(op_code), .op_addr(op_addr), .sus_req(sus_req), .res_req(res_req)
  );

  spi_st_readout u_read (
    .clk(clk), .rst(rst), .sel(sel), .sclk_fall(sclk_fall),
    .rd_phase(rd_phase), .opcode(opcode), .stat1(stat1_w),
    .stat2(stat2_w), .do_o(do_o)
  );
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk
  import spi_st_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       op_done,
  input logic       op_start,
  input logic [7:0] op_code,
  input logic       sus_req,
  input logic       res_req,
  input logic       busy,
  input logic       latch,
  input logic       paused
);
  AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    op_start |-> $past(latch)); // R4
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    op_start |-> !$past(busy)); // R8
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    op_start |-> busy); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_start, sus_req, res_req})); // R6
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (op_done && busy) |=> (!busy && !latch)); // R7
  AST_PAUSE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    sus_req |-> ($past(busy) && !$past(paused) && paused && !busy)); // R9
  AST_CONTINUE_GATE: assert property (@(posedge clk) disable iff (rst)
    res_req |-> ($past(paused) && !$past(busy) && !paused && busy)); // R10
  AST_NO_ERASE_PAUSED: assert property (@(posedge clk) disable iff (rst)
    (op_start && is_erase(op_code)) |-> !$past(paused)); // R11
endmodule

bind spi_status_ctrl spi_status_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .op_done(op_done), .op_start(op_start),
  .op_code(op_code), .sus_req(sus_req), .res_req(res_req),
  .busy(stat1_w[0]), .latch(stat1_w[1]), .paused(stat2_w[7])
);

// File: tb/tb_spi_status_ctrl.sv
module tb_spi_status_ctrl;
  localparam int HALF = 64;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, di = 1'b0, op_done = 1'b0;
  logic        do_o, op_start, sus_req, res_req;
  logic [7:0]  op_code;
  logic [23:0] op_addr;

  spi_status_ctrl dut (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .di(di), .op_done(op_done),
    .do_o(do_o), .op_start(op_start), .op_code(op_code), .op_addr(op_addr),
    .sus_req(sus_req), .res_req(res_req)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, n_start = 0, n_sus = 0, n_res = 0;
  logic [7:0]  last_code = '0;
  logic [23:0] last_addr = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  act_byte;
  event        got;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      if (op_start) begin n_start++; last_code = op_code; last_addr = op_addr; end
      if (sus_req) n_sus++;
      if (res_req) n_res++;
    end
  end

  // Monitor: pops the expected byte for each byte the reader assembles
  initial begin
    forever begin
      @(got);
      if (exp_q.size() == 0) chk("R2 unexpected byte", act_byte, 32'hFFFF_FFFF);
      else chk(tag_q.pop_front(), act_byte, exp_q.pop_front());
    end
  end

  task automatic frame(input logic [63:0] bits, input int nbits);
    cs_n = 1'b0; #HALF;
    for (int i = 0; i < nbits; i++) begin
      di = bits[63-i]; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    #HALF; cs_n = 1'b1; di = 1'b0; #(HALF*2);
  endtask

  task automatic read_stat(input logic [7:0] op, input logic [7:0] v, input string tag,
                           input int nbytes = 1);
    logic [7:0] b;
    for (int k = 0; k < nbytes; k++) begin exp_q.push_back(v); tag_q.push_back(tag); end
    cs_n = 1'b0; #HALF;
    for (int i = 0; i < 8; i++) begin
      di = op[7-i]; #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    di = 1'b0;
    for (int k = 0; k < nbytes; k++) begin
      b = '0;
      for (int i = 0; i < 8; i++) begin
        #HALF; sclk = 1'b1; b = {b[6:0], do_o}; #HALF; sclk = 1'b0;
      end
      act_byte = b; ->got;
    end
    #HALF; cs_n = 1'b1; #(HALF*2);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    chk("scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(64'd200000 * 8);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1; #80; rst = 1'b0; #40;
    // R3 reset state
    read_stat(8'h05, 8'h00, "R3 status-1 after reset");
    read_stat(8'h35, 8'h00, "R3 status-2 after reset");
    chk("R3 no strobe after reset", n_start + n_sus + n_res, 0);
    // R1 latch on/off and frame length
    frame({8'h06, 56'h0}, 9);
    read_stat(8'h05, 8'h00, "R1 9-bit latch-on ignored");
    frame({8'h06, 56'h0}, 8);
    read_stat(8'h05, 8'h02, "R1 latch set");
    read_stat(8'h05, 8'h02, "R2 repeated status-1", 3);
    frame({8'h04, 56'h0}, 8);
    read_stat(8'h05, 8'h00, "R1 latch cleared");
    // R4 erase refused without latch
    frame({8'h20, 24'h123456, 32'h0}, 32);
    chk("R4 erase without latch", n_start, 0);
    read_stat(8'h05, 8'h00, "R4 status unchanged");
    // R5 status write framing
    frame({8'h06, 56'h0}, 8);
    frame({8'h01, 8'hFF, 48'h0}, 12);
    read_stat(8'h05, 8'h02, "R5 12-bit write discarded");
    chk("R5 no start on bad length", n_start, 0);
    frame({8'h01, 8'hFF, 48'h0}, 16);
    read_stat(8'h05, 8'hFF, "R5 16-bit write with busy");
    chk("R6 start count", n_start, 1);
    chk("R6 start opcode", last_code, 8'h01);
    // R8 latch-off ignored while busy; R9 pause ignored during status write
    frame({8'h04, 56'h0}, 8);
    read_stat(8'h05, 8'hFF, "R8 latch-off ignored while busy");
    frame({8'h75, 56'h0}, 8);
    read_stat(8'h35, 8'h00, "R9 pause ignored on status write");
    chk("R9 no pause strobe", n_sus, 0);
    done_pulse();
    read_stat(8'h05, 8'hFC, "R7 done clears busy and latch");
    // R5 24-bit write reaches quad-enable
    frame({8'h06, 56'h0}, 8);
    frame({8'h01, 8'h00, 8'h02, 40'h0}, 24);
    read_stat(8'h05, 8'h03, "R5 24-bit write status-1");
    read_stat(8'h35, 8'h02, "R5 24-bit write quad-enable", 2);
    done_pulse();
    read_stat(8'h05, 8'h00, "R7 idle after write");
    // R6 sector erase, R9 pause
    frame({8'h06, 56'h0}, 8);
    frame({8'h20, 24'h123456, 32'h0}, 32);
    chk("R6 erase start", n_start, 3);
    chk("R6 erase opcode", last_code, 8'h20);
    chk("R6 erase address", last_addr, 24'h123456);
    frame({8'h75, 56'h0}, 8);
    chk("R9 pause strobe", n_sus, 1);
    read_stat(8'h05, 8'h02, "R9 busy cleared by pause");
    read_stat(8'h35, 8'h82, "R9 pause flag set");
    // R11 refusals and program while paused
    frame({8'h20, 24'h000000, 32'h0}, 32);
    frame({8'h01, 8'h00, 48'h0}, 16);
    chk("R11 erase and status write refused", n_start, 3);
    frame({8'h02, 24'h000100, 8'hA5, 24'h0}, 40);
    chk("R11 program accepted while paused", n_start, 4);
    chk("R6 program address", last_addr, 24'h000100);
    read_stat(8'h05, 8'h03, "R11 program busy");
    // R10 continue gating
    frame({8'h7A, 56'h0}, 8);
    chk("R10 continue refused while busy", n_res, 0);
    done_pulse();
    read_stat(8'h05, 8'h00, "R7 program done");
    frame({8'h7A, 56'h0}, 8);
    chk("R10 continue accepted", n_res, 1);
    read_stat(8'h35, 8'h02, "R10 pause flag cleared");
    read_stat(8'h05, 8'h01, "R10 busy again");
    done_pulse();
    frame({8'h7A, 56'h0}, 8);
    chk("R10 continue without pause", n_res, 1);
    // R6 program length and chip erase
    frame({8'h06, 56'h0}, 8);
    frame({8'h02, 24'h000100, 8'hA5, 24'h0}, 44);
    chk("R6 partial-byte program refused", n_start, 4);
    read_stat(8'h05, 8'h02, "R6 status after refused program");
    frame({8'hC7, 56'h0}, 8);
    chk("R6 chip erase start", n_start, 5);
    chk("R6 chip erase opcode", last_code, 8'hC7);
    chk("R6 chip erase address", last_addr, 24'h0);
    done_pulse();
    read_stat(8'h05, 8'h00, "R7 idle at end");
    #200;
    finish_run();
  end
endmodule